// File: doc/BRIEF.md
# Binary AND-Popcount Accumulator

This block produces one element of a single-bit matrix product. Each request carries a 256-bit row of A, a 256-bit column of B, a signed 32-bit running sum and an accumulate enable. The two vectors are combined with a bitwise AND. The set bits of the combined vector are counted, and the count is added to the running sum. When the enable is low, the count alone is returned.

Requests enter through a valid/ready handshake. Results leave through a valid/ready handshake as well. The datapath has three register stages. The first stage forms partial counts over fixed-width slices. The second stage sums those partial counts. The third stage performs the final add. With no backpressure the block accepts one request per cycle. When the consumer holds back, every stage freezes at once.

Top module: `bitand_popcnt_mac`

## Requirements
- R1: With `req_accum_en` = 1, the result equals `req_acc` plus the number of positions where both `req_a` and `req_b` are 1.
- R2: With `req_accum_en` = 0, the result equals that count alone, and the value on `req_acc` has no effect on it.
- R3: The add wraps modulo 2^32 with no saturation. For example, 0x7FFFFFFF + 256 gives 0x800000FF.
- R4: An idle block accepts a request on a rising edge while `res_ready` is high. `res_valid` then goes high after the third rising edge, counting the accepting edge, and not earlier.
- R5: While `res_ready` stays high, `req_ready` stays high, so N back-to-back requests are accepted in N cycles.
- R6: While `res_valid` is high and `res_ready` is low, `res_data` and `res_valid` hold on the next cycle, and `req_ready` is low.
- R7: Every accepted request yields exactly one result, in acceptance order.
- R8: After reset, `res_valid` is low.
- R9: The count covers the full range of 0 to 256. All-zero operands give 0, and all-one operands give 256.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low reset; clears the stage valid bits |
| req_valid | input | 1 | A request is offered |
| req_ready | output | 1 | The block takes the request on this edge |
| req_a | input | 256 | Row vector of A |
| req_b | input | 256 | Column vector of B |
| req_acc | input | 32 | Signed running sum to add to |
| req_accum_en | input | 1 | 1: add the count to `req_acc`; 0: return the count alone |
| res_valid | output | 1 | A result is offered |
| res_ready | input | 1 | The consumer takes the result |
| res_data | output | 32 | Signed result |

## Verification
The hardest condition to reach is a stall that freezes a full pipeline. This happens when `res_ready` drops while all three stages hold requests and a fourth request is waiting at the input. It is the point where a request could be lost or issued twice. The stimulus sends long back-to-back bursts while `res_ready` is pulled low on a pseudo-random pattern, about one cycle in three. A scoreboard queue compares each result, in order, against a sum computed independently from the operands. Separate directed requests cover wraparound of the add, both extremes of the count, and the ignored running sum.

// File: rtl/bitand_popcnt_mac.sv
module bitand_popcnt_mac #(
  parameter int VEC_W   = 256,
  parameter int ACC_W   = 32,
  parameter int CHUNK_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             req_valid,
  output logic             req_ready,
  input  logic [VEC_W-1:0] req_a,
  input  logic [VEC_W-1:0] req_b,
  input  logic [ACC_W-1:0] req_acc,
  input  logic             req_accum_en,
  output logic             res_valid,
  input  logic             res_ready,
  output logic [ACC_W-1:0] res_data
);
  localparam int NCH   = VEC_W / CHUNK_W;
  localparam int PCW   = $clog2(CHUNK_W + 1);
  localparam int CNT_W = $clog2(VEC_W + 1);

  logic             adv;
  logic [VEC_W-1:0] hits;
  logic [PCW-1:0]   part_d [NCH];
  logic [PCW-1:0]   part_q [NCH];
  logic [CNT_W-1:0] cnt_d, cnt_q;
  logic [ACC_W-1:0] acc1_q, acc2_q;
  logic             v1_q, v2_q;

  assign adv       = !res_valid || res_ready;
  assign req_ready = adv;
  assign hits      = req_a & req_b;

  genvar c;
  generate
    for (c = 0; c < NCH; c++) begin : g_slice
      always_comb begin
        part_d[c] = '0;
        for (int i = 0; i < CHUNK_W; i++)
          part_d[c] = part_d[c] + PCW'(hits[c*CHUNK_W+i]);
      end
    end
  endgenerate

  always_comb begin
    cnt_d = '0;
    for (int k = 0; k < NCH; k++)
      cnt_d = cnt_d + CNT_W'(part_q[k]);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      v1_q      <= 1'b0;
      v2_q      <= 1'b0;
      res_valid <= 1'b0;
    end else if (adv) begin
      v1_q      <= req_valid;
      v2_q      <= v1_q;
      res_valid <= v2_q;
    end
  end

  always_ff @(posedge clk) begin
    if (adv) begin
      part_q   <= part_d;
      acc1_q   <= req_accum_en ? req_acc : '0;
      cnt_q    <= cnt_d;
      acc2_q   <= acc1_q;
      res_data <= acc2_q + ACC_W'(cnt_q);
    end
  end
endmodule

module bitand_popcnt_mac_chk #(
  parameter int ACC_W = 32
) (
  input logic             clk,
  input logic             rst_n,
  input logic             req_valid,
  input logic             req_ready,
  input logic             res_valid,
  input logic             res_ready,
  input logic [ACC_W-1:0] res_data
);
  logic [2:0] inflight;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) inflight <= '0;
    else inflight <= inflight + 3'(req_valid && req_ready) - 3'(res_valid && res_ready);
  end

  // R8
  reset_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $past(!rst_n) |-> !res_valid);

  // R6
  stall_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (res_valid && !res_ready) |=> (res_valid && $stable(res_data)));

  // R6
  stall_block_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (res_valid && !res_ready) |-> !req_ready);

  // R7
  inflight_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    inflight <= 3'd3);

  // R7
  no_phantom_chk: assert property (@(posedge clk) disable iff (!rst_n)
    res_valid |-> (inflight != 3'd0));
endmodule

bind bitand_popcnt_mac bitand_popcnt_mac_chk #(.ACC_W(ACC_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
  .res_valid(res_valid), .res_ready(res_ready), .res_data(res_data)
);

// File: tb/bitand_popcnt_mac_test.sv
`timescale 1ns/100ps
module bitand_popcnt_mac_test;
  logic clk = 0, rst_n = 0;
  logic req_valid = 0, req_ready, req_accum_en = 0;
  logic [255:0] req_a = '0, req_b = '0;
  logic [31:0] req_acc = '0;
  logic res_valid, res_ready = 1;
  logic [31:0] res_data;

  int checks = 0, fails = 0;
  int cycles = 0;
  bit stall_mode = 0, done = 0;
  logic [31:0] expq [$];
  string tagq [$];

  bitand_popcnt_mac uut (.*);

  always #2.5 clk = ~clk;
  always @(posedge clk) cycles++;

  always @(negedge clk)
    res_ready <= stall_mode ? (($urandom % 3) != 0) : 1'b1;

  task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic send(input logic [255:0] a, input logic [255:0] b,
                      input logic [31:0] acc, input bit en, input string tag);
    logic [31:0] cnt;
    req_a = a; req_b = b; req_acc = acc; req_accum_en = en; req_valid = 1;
    cnt = $countones(a & b);
    forever begin
      #1;
      if (req_ready) break;
      @(negedge clk);
    end
    expq.push_back(en ? acc + cnt : cnt);
    tagq.push_back(tag);
    @(posedge clk);
    @(negedge clk);
    req_valid = 0;
  endtask

  // scoreboard monitor; also R6 stall observation
  bit        held = 0;
  logic [31:0] held_data;
  always @(negedge clk) begin
    #1;
    if (rst_n) begin
      if (held) begin
        check(res_valid === 1'b1 && res_data === held_data, "R6 hold", res_data, held_data);
        held = 0;
      end
      if (res_valid && !res_ready) begin
        check(req_ready === 1'b0, "R6 req_ready low", {31'b0, req_ready}, 32'd0);
        held = 1; held_data = res_data;
      end
      if (res_valid && res_ready) begin
        if (expq.size() == 0)
          check(0, "R7 extra result", res_data, 32'hx);
        else begin
          logic [31:0] e; string t;
          e = expq.pop_front(); t = tagq.pop_front();
          check(res_data === e, t, res_data, e);
        end
      end
    end
  end

  initial begin
    #(5.0 * 150000);
    if (!done) begin
      fails++; checks++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("  == %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  end

  initial begin
    logic [255:0] ones;
    ones = '1;
    repeat (3) @(negedge clk);
    #1 check(res_valid === 1'b0, "R8 reset", {31'b0, res_valid}, 32'd0);
    rst_n = 1;
    @(negedge clk); #1 check(res_valid === 1'b0, "R8 after release", {31'b0, res_valid}, 32'd0);
    @(negedge clk);

    // R4 latency from idle
    send(ones, ones, 32'd5, 1, "R1 ones+5");
    #1 check(res_valid === 1'b0, "R4 after edge1", {31'b0, res_valid}, 32'd0);
    @(negedge clk); #1 check(res_valid === 1'b0, "R4 after edge2", {31'b0, res_valid}, 32'd0);
    @(negedge clk); #1 check(res_valid === 1'b1, "R4 after edge3", {31'b0, res_valid}, 32'd1);
    @(negedge clk);

    send('0, '0, 32'd0, 0, "R9 zero count");
    send(ones, ones, 32'hDEADBEEF, 0, "R9 full 256 R2 acc ignored");
    send(ones, '0, 32'h12345678, 0, "R2 acc ignored zero");
    send(ones, ones, 32'h7FFFFFFF, 1, "R3 wrap positive");
    send(ones, ones, 32'hFFFFFF80, 1, "R3 wrap through zero");
    send({128{2'b10}}, ones, 32'hFFFFFFFF, 1, "R1 alternating");
    send({128{2'b10}}, {128{2'b01}}, 32'd77, 1, "R1 disjoint");

    // R5 throughput
    begin
      int t0;
      repeat (4) @(negedge clk);
      t0 = cycles;
      for (int i = 0; i < 16; i++)
        send({8{$urandom}}, {8{$urandom}}, $urandom, 1'($urandom), "R1 R2 burst");
      check(cycles - t0 == 16, "R5 throughput", 32'(cycles - t0), 32'd16);
    end

    // R6 R7 random backpressure
    stall_mode = 1;
    for (int i = 0; i < 300; i++)
      send({8{$urandom}}, {8{$urandom}}, $urandom, 1'($urandom), "R7 stalled stream");
    stall_mode = 0;
    repeat (20) @(negedge clk);
    check(expq.size() == 0, "R7 all returned", 32'(expq.size()), 32'd0);

    done = 1;
    $display("  == %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end
endmodule